// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves an effective page to a real page when no block translation has hit. It picks one of sixteen segment descriptors using the top four bits of the effective address. From that descriptor and the current privilege state it works out a protection key and whether instruction fetch is allowed. It then hashes the virtual segment identifier with the page index to find a group of eight page-table entries in memory, and reads them one word at a time through a single-outstanding request port.

When the first group yields no usable result, the engine searches a second group found through the complemented hash. If an entry is found, the engine sets its referenced flag and, on a permitted store, its changed flag. It writes the entry's second word back only when one of those flags was actually clear. The caller gets a real page number, read and write permission bits and a two-bit status, all marked by a one-cycle completion pulse.

Top module: `hpt_walker`

## Requirements
- R1: The key is 1 when descriptor bit 29 is set and `user_i` is 1, or when descriptor bit 30 is set and `user_i` is 0; otherwise it is 0. The descriptor is entry `ea_page_i[19:16]` of `seg_table_i`, where entry n occupies bits 32n+31:32n.
- R2: A descriptor with bit 31 set completes with status MISS, and a fetch (`fetch_i`=1) through a descriptor with bit 28 set completes with status NOEXEC. Neither case issues any memory request.
- R3: Take VSID as descriptor bits 23:0, PI as `ea_page_i[15:0]` and h1 = ((VSID[18:0] xor PI) and 0x7FFFF) << 6. The group address is (cfg and 0xFFFF0000) or (h and ((cfg[8:0] << 16) or 0xFFC0)). Entry i has its first word at group + 8i and its second word at group + 8i + 4.
- R4: The second group uses h2 = (not h1) and 0x01FFFFC0 and is searched only when the first group's result is not OK. The final status is the second group's result unless that result is MISS, in which case the first group's result is kept.
- R5: An entry qualifies when its first word has bit 31 set, has bit 6 equal to the group number (0 first, 1 second), and, with bits 31 and 6 cleared, equals (VSID << 7) or (PI >> 10). No other entry is used.
- R6: With key 0, read is granted and write is granted unless the protection field (second-word bits 1:0) is 3. With key 1, field 0 grants nothing, fields 1 and 3 grant read only, and field 2 grants both. A request that is not granted gives status PROT.
- R7: When qualifying entries in one group differ in any second-word bit selected by 0xFFFFF07B, that group counts as MISS and nothing is written back. When they agree, the first qualifying entry is the one used.
- R8: For the entry used, the write-back sets bit 8, and also sets bit 7 on a granted store. When bit 7 stays clear, the reported write permission is 0. The second word is written back only if its value changes.
- R9: `rpn_o` is second-word bits 31:12 of the entry used. A MISS or NOEXEC result reports `rpn_o`=0 and both permissions 0.
- R10: A request holds its address, data and direction until `mem_req_ready_i`. A read waits for `mem_rsp_valid_i` before the next request is made, and a write is complete once it is accepted.
- R11: `done_o` is high for exactly one cycle per walk. Status codes are 0 OK, 1 MISS, 2 PROT, 3 NOEXEC. The result stays on the outputs until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; ignored while busy |
| ea_page_i | input | 20 | Effective address bits 31:12 |
| fetch_i | input | 1 | Access is an instruction fetch |
| write_i | input | 1 | Access is a store |
| user_i | input | 1 | Requester is in user state |
| seg_table_i | input | 512 | Sixteen 32-bit segment descriptors |
| table_cfg_i | input | 32 | Table base (31:16) and size mask (8:0) |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Request byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result status |
| rpn_o | output | 20 | Real page number |
| perm_read_o | output | 1 | Read permitted |
| perm_write_o | output | 1 | Write permitted |

## Verification
The assertions check the request port on every cycle: a stalled request holds steady, no request is made while a read response is pending, and every write-back sets the referenced flag and targets a second word. They also check every completion: the pulse lasts one cycle, an OK result grants the access that was asked for, and MISS or NOEXEC results carry no page number or permissions. Only the bench scenarios can show that the hash and group addresses are right, that the key and protection table are right, how the two groups combine, that conflicting duplicates are rejected, and that the write-back happens only when a flag changes.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_MISS   = 2'd1,
    ST_PROT   = 2'd2,
    ST_NOEXEC = 2'd3
  } walk_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ0, S_RSP0, S_REQ1, S_RSP1, S_EVAL, S_WRITE, S_FINISH
  } walk_state_e;

  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;
  localparam logic [31:0] REF_FLAG   = 32'h0000_0100;
  localparam logic [31:0] CHG_FLAG   = 32'h0000_0080;
  localparam logic [31:0] SEC_HASH_MASK = 32'h01FF_FFC0;

  function automatic logic f_key(input logic usr_key, input logic sup_key, input logic user);
    return (usr_key & user) | (sup_key & ~user);
  endfunction

  function automatic logic [31:0] f_hash_first(input logic [18:0] vsid_lo, input logic [15:0] pidx);
    return {7'b0, vsid_lo ^ {3'b0, pidx}, 6'b0};
  endfunction

  function automatic logic [31:0] f_hash_second(input logic [31:0] h);
    return ~h & SEC_HASH_MASK;
  endfunction

  function automatic logic [31:0] f_group(input logic [15:0] base_hi, input logic [8:0] size,
                                          input logic [31:0] h);
    return {base_hi, 16'b0} | (h & {7'b0, size, 16'hFFC0});
  endfunction

  function automatic logic [31:0] f_tag(input logic [23:0] vsid, input logic [15:0] pidx);
    return {1'b0, vsid, 1'b0, pidx[15:10]};
  endfunction

  // returns {write, read}
  function automatic logic [1:0] f_access(input logic key, input logic [1:0] pp);
    if (!key) return {pp != 2'd3, 1'b1};
    case (pp)
      2'd0:    return 2'b00;
      2'd2:    return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [23:0]      vsid,
  input  logic [15:0]      pidx,
  input  logic [15:0]      base_hi,
  input  logic [8:0]       size,
  input  logic             second,
  input  logic [IDX_W-1:0] idx,
  input  logic             word_hi,
  output logic [31:0]      tag,
  output logic [31:0]      entry_addr
);
  localparam int ENTRY_SHIFT = 3;

  logic [31:0] h_first, h_sel, grp;

  always_comb begin
    h_first    = f_hash_first(vsid[18:0], pidx);
    h_sel      = second ? f_hash_second(h_first) : h_first;
    grp        = f_group(base_hi, size, h_sel);
    tag        = f_tag(vsid, pidx);
    entry_addr = grp + (32'(idx) << ENTRY_SHIFT) + (word_hi ? 32'd4 : 32'd0);
  end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval
  import hpt_pkg::*;
(
  input  logic [31:0] first_word,
  input  logic        second,
  input  logic [31:0] tag,
  input  logic [31:0] kept,
  input  logic [31:0] cand,
  input  logic        key,
  input  logic        is_store,
  output logic        qualifies,
  output logic        disagree,
  output logic        acc_r,
  output logic        acc_w,
  output logic        granted,
  output logic        eff_w,
  output logic [31:0] updated,
  output logic        changed
);
  logic [1:0] acc;

  always_comb begin
    qualifies = first_word[31] && (first_word[6] == second) &&
                ((first_word & 32'h7FFF_FFBF) == tag);
    disagree  = ((kept ^ cand) & AGREE_MASK) != 32'd0;
    acc       = f_access(key, kept[1:0]);
    acc_r     = acc[0];
    acc_w     = acc[1];
    granted   = is_store ? acc_w : acc_r;
    updated   = kept | REF_FLAG | ((is_store && granted) ? CHG_FLAG : 32'd0);
    eff_w     = acc_w && (kept[7] || (is_store && granted));
    changed   = updated != kept;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int SEG_COUNT     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [19:0]             ea_page_i,
  input  logic                    fetch_i,
  input  logic                    write_i,
  input  logic                    user_i,
  input  logic [SEG_COUNT*32-1:0] seg_table_i,
  input  logic [31:0]             table_cfg_i,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic                    mem_req_write_o,
  output logic [31:0]             mem_req_addr_o,
  output logic [31:0]             mem_req_wdata_o,
  input  logic                    mem_rsp_valid_i,
  input  logic [31:0]             mem_rsp_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [1:0]              status_o,
  output logic [19:0]             rpn_o,
  output logic                    perm_read_o,
  output logic                    perm_write_o
);
  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam int SEG_W = $clog2(SEG_COUNT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_state_e  state_q;
  logic [23:0]  vsid_q;
  logic [15:0]  pidx_q;
  logic [15:0]  base_q;
  logic [8:0]   size_q;
  logic         key_q, wr_q, pass_q, cont_q;
  logic [IDX_W-1:0] idx_q, good_q;
  logic         have_q, bad_q;
  logic [31:0]  keep_q, wb_q;
  walk_status_e status_q, prim_q;
  logic [19:0]  rpn_q;
  logic         pr_q, pw_q;

  // selected descriptor and observable events
  logic [31:0] seg_sel;
  logic        rsp_wait, req_fire, last_entry, grp_ok, cont_c;
  logic        unused_bits;
  walk_status_e gres;

  assign seg_sel     = seg_table_i[32*int'(ea_page_i[19 -: SEG_W]) +: 32];
  assign unused_bits = ^{seg_sel[27:24], table_cfg_i[15:9]};
  assign rsp_wait    = (state_q == S_RSP0) || (state_q == S_RSP1);
  assign last_entry  = (idx_q == LAST_IDX);

  logic [31:0] tag, entry_addr;
  hpt_addr_gen #(.IDX_W(IDX_W)) u_addr (
    .vsid      (vsid_q),
    .pidx      (pidx_q),
    .base_hi   (base_q),
    .size      (size_q),
    .second    (pass_q),
    .idx       (state_q == S_WRITE ? good_q : idx_q),
    .word_hi   (state_q == S_REQ1 || state_q == S_WRITE),
    .tag       (tag),
    .entry_addr(entry_addr)
  );

  logic qualifies, disagree, acc_r, acc_w, granted, eff_w, changed;
  logic [31:0] updated;
  hpt_entry_eval u_eval (
    .first_word(mem_rsp_rdata_i),
    .second    (pass_q),
    .tag       (tag),
    .kept      (keep_q),
    .cand      (mem_rsp_rdata_i),
    .key       (key_q),
    .is_store  (wr_q),
    .qualifies (qualifies),
    .disagree  (disagree),
    .acc_r     (acc_r),
    .acc_w     (acc_w),
    .granted   (granted),
    .eff_w     (eff_w),
    .updated   (updated),
    .changed   (changed)
  );

  always_comb begin
    mem_req_valid_o = (state_q == S_REQ0) || (state_q == S_REQ1) || (state_q == S_WRITE);
    mem_req_write_o = (state_q == S_WRITE);
    mem_req_addr_o  = entry_addr;
    mem_req_wdata_o = (state_q == S_WRITE) ? wb_q : 32'd0;
    req_fire        = mem_req_valid_o && mem_req_ready_i;
    grp_ok          = have_q && !bad_q;
    if (!grp_ok)      gres = ST_MISS;
    else if (granted) gres = ST_OK;
    else              gres = ST_PROT;
    cont_c          = !pass_q && (gres != ST_OK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      vsid_q   <= '0;
      pidx_q   <= '0;
      base_q   <= '0;
      size_q   <= '0;
      key_q    <= 1'b0;
      wr_q     <= 1'b0;
      pass_q   <= 1'b0;
      cont_q   <= 1'b0;
      idx_q    <= '0;
      good_q   <= '0;
      have_q   <= 1'b0;
      bad_q    <= 1'b0;
      keep_q   <= '0;
      wb_q     <= '0;
      status_q <= ST_OK;
      prim_q   <= ST_MISS;
      rpn_q    <= '0;
      pr_q     <= 1'b0;
      pw_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          vsid_q <= seg_sel[23:0];
          pidx_q <= ea_page_i[15:0];
          base_q <= table_cfg_i[31:16];
          size_q <= table_cfg_i[8:0];
          key_q  <= f_key(seg_sel[29], seg_sel[30], user_i);
          wr_q   <= write_i;
          pass_q <= 1'b0;
          idx_q  <= '0;
          have_q <= 1'b0;
          bad_q  <= 1'b0;
          prim_q <= ST_MISS;
          rpn_q  <= '0;
          pr_q   <= 1'b0;
          pw_q   <= 1'b0;
          if (seg_sel[31]) begin
            status_q <= ST_MISS;
            state_q  <= S_FINISH;
          end else if (fetch_i && seg_sel[28]) begin
            status_q <= ST_NOEXEC;
            state_q  <= S_FINISH;
          end else begin
            state_q  <= S_REQ0;
          end
        end
        S_REQ0: if (req_fire) state_q <= S_RSP0;
        S_RSP0: if (mem_rsp_valid_i) begin
          if (qualifies) state_q <= S_REQ1;
          else if (last_entry) state_q <= S_EVAL;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_REQ0;
          end
        end
        S_REQ1: if (req_fire) state_q <= S_RSP1;
        S_RSP1: if (mem_rsp_valid_i) begin
          if (!have_q) begin
            have_q <= 1'b1;
            keep_q <= mem_rsp_rdata_i;
            good_q <= idx_q;
          end
          if (have_q && disagree) begin
            bad_q   <= 1'b1;
            state_q <= S_EVAL;
          end else if (last_entry) begin
            state_q <= S_EVAL;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_REQ0;
          end
        end
        S_EVAL: begin
          if (grp_ok) begin
            rpn_q <= keep_q[31:12];
            pr_q  <= acc_r;
            pw_q  <= eff_w;
            wb_q  <= updated;
          end
          if (!pass_q) begin
            if (gres == ST_OK) status_q <= ST_OK;
            else prim_q <= gres;
          end else begin
            status_q <= (gres != ST_MISS) ? gres : prim_q;
          end
          cont_q <= cont_c;
          if (grp_ok && changed) state_q <= S_WRITE;
          else if (cont_c) begin
            pass_q  <= 1'b1;
            idx_q   <= '0;
            have_q  <= 1'b0;
            bad_q   <= 1'b0;
            state_q <= S_REQ0;
          end else state_q <= S_FINISH;
        end
        S_WRITE: if (req_fire) begin
          if (cont_q) begin
            pass_q  <= 1'b1;
            idx_q   <= '0;
            have_q  <= 1'b0;
            bad_q   <= 1'b0;
            state_q <= S_REQ0;
          end else state_q <= S_FINISH;
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FINISH);
  assign status_o     = status_q;
  assign rpn_o        = rpn_q;
  assign perm_read_o  = pr_q;
  assign perm_write_o = pw_q;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [1:0]  status,
  input logic [19:0] rpn,
  input logic        perm_r,
  input logic        perm_w,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_wait,
  input logic        store_walk
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wait |-> !req_valid);

  p_wb_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> req_wdata[8]);

  p_wb_second_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_addr[2:0] == 3'b100));

  p_ok_grants_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> (store_walk ? perm_w : perm_r));

  p_miss_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == 2'd1 || status == 2'd3)) |-> (rpn == 20'd0 && !perm_r && !perm_w));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done_o),
  .status    (status_o),
  .rpn       (rpn_o),
  .perm_r    (perm_read_o),
  .perm_w    (perm_write_o),
  .req_valid (mem_req_valid_o),
  .req_ready (mem_req_ready_i),
  .req_write (mem_req_write_o),
  .req_addr  (mem_req_addr_o),
  .req_wdata (mem_req_wdata_o),
  .rsp_wait  (rsp_wait),
  .store_walk(wr_q)
);

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         start = 0, fetch = 0, wr = 0, user = 0;
  logic [19:0]  ea_pg = '0;
  logic [511:0] segs = '0;
  logic [31:0]  cfg = '0;
  logic         req_valid, req_write, req_ready = 1'b1;
  logic [31:0]  req_addr, req_wdata;
  logic         rsp_valid = 1'b0;
  logic [31:0]  rsp_data = '0;
  logic         busy, done, pr, pw;
  logic [1:0]   status;
  logic [19:0]  rpn;

  hpt_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ea_page_i(ea_pg), .fetch_i(fetch),
    .write_i(wr), .user_i(user), .seg_table_i(segs), .table_cfg_i(cfg),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_write_o(req_write),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_rdata_i(rsp_data), .busy_o(busy), .done_o(done), .status_o(status),
    .rpn_o(rpn), .perm_read_o(pr), .perm_write_o(pw)
  );

  int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // memory model: one response the cycle after a read is accepted
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (req_write) begin
        mem[req_addr] = req_wdata;
        wr_cnt++;
      end else begin
        rsp_valid <= 1'b1;
        rsp_data  <= mrd(req_addr);
        rd_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    req_ready = (cyc % 3) != 2;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  localparam logic [31:0] EA = 32'h1234_5000;

  function automatic logic [31:0] grp_of(input logic [31:0] ea, input logic [31:0] sg,
                                         input logic [31:0] c, input bit sec);
    logic [31:0] h, m;
    h = (((sg & 32'hFF_FFFF) ^ ((ea >> 12) & 32'hFFFF)) & 32'h7FFFF) << 6;
    if (sec) h = (~h) & 32'h01FF_FFC0;
    m = ((c & 32'h1FF) << 16) | 32'hFFC0;
    return (c & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] w0_of(input logic [31:0] ea, input logic [31:0] sg, input bit hbit);
    return 32'h8000_0000 | ((sg & 32'hFF_FFFF) << 7) | (((ea >> 12) & 32'hFFFF) >> 10) |
           (hbit ? 32'h40 : 32'h0);
  endfunction

  task automatic put(input bit sec, input int slot, input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] g;
    g = grp_of(EA, segs[32 +: 32], cfg, sec);
    mem[g + 8*slot]     = w0;
    mem[g + 8*slot + 4] = w1;
  endtask

  function automatic logic [31:0] w1_at(input bit sec, input int slot);
    return mrd(grp_of(EA, segs[32 +: 32], cfg, sec) + 8*slot + 4);
  endfunction

  task automatic setup(input logic [31:0] sg, input logic [31:0] c);
    mem.delete();
    segs = '0;
    segs[32 +: 32] = sg;
    cfg = c;
  endtask

  task automatic run(input bit f, input bit w, input bit u);
    int n;
    @(negedge clk);
    ea_pg = EA[31:12]; fetch = f; wr = w; user = u; start = 1'b1;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R11 walk completes", {31'b0, done}, 32'd1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk("R11 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 reset done", {31'b0, done}, 0);
    chk("R10 reset no request", {31'b0, req_valid}, 0);
    chk("R11 reset idle", {31'b0, busy}, 0);
  endtask

  task automatic t_read_hit;
    setup(32'h0000_0123, 32'h0020_0000);
    put(0, 3, w0_of(EA, 32'h123, 0), 32'hABCD_E002);
    run(0, 0, 0);
    chk("R3 read hit status", status, 0);
    chk("R9 rpn", rpn, 20'hABCDE);
    chk("R8 write removed until changed", {pr, pw}, 2'b10);
    after_done();
    chk("R8 reference written", w1_at(0, 3), 32'hABCD_E102);
    chk("R8 one write", wr_cnt, 1);
  endtask

  task automatic t_write_hit;
    setup(32'h0000_0123, 32'h0020_0000);
    put(0, 0, w0_of(EA, 32'h123, 0), 32'hABCD_E000);
    run(0, 1, 0);
    chk("R6 key0 pp0 store", status, 0);
    chk("R8 store perms", {pr, pw}, 2'b11);
    chk("R8 ref+chg written", w1_at(0, 0), 32'hABCD_E180);
  endtask

  task automatic t_secondary;
    logic [31:0] g1;
    setup(32'h0000_0123, 32'h0040_0003);
    g1 = grp_of(EA, 32'h123, cfg, 0);
    mem[g1 + 16] = w0_of(EA, 32'h123, 1);  mem[g1 + 20] = 32'h7777_7002;
    mem[g1 + 32] = w0_of(EA, 32'h123, 0) & 32'h7FFF_FFFF; mem[g1 + 36] = 32'h7777_7002;
    put(1, 0, w0_of(EA, 32'h123, 1), 32'h1357_9002);
    run(0, 0, 0);
    chk("R4 secondary hit", status, 0);
    chk("R4 secondary rpn", rpn, 20'h13579);
    chk("R5 decoys skipped read count", rd_cnt, 17);
  endtask

  task automatic t_miss;
    logic [31:0] g1;
    setup(32'h0000_0123, 32'h0020_0000);
    g1 = grp_of(EA, 32'h123, cfg, 0);
    mem[g1 + 8] = w0_of(EA, 32'h123, 1); mem[g1 + 12] = 32'h7777_7002;
    run(0, 0, 0);
    chk("R5 miss status", status, 1);
    chk("R4 both groups read", rd_cnt, 16);
    chk("R9 miss clean", {rpn, pr, pw}, 0);
    chk("R8 miss no write", wr_cnt, 0);
  endtask

  task automatic t_keys;
    setup(32'h2000_0123, 32'h0020_0000);
    put(0, 2, w0_of(EA, 32'h2000_0123, 0), 32'hABCD_E000);
    run(0, 0, 1);
    chk("R1 R6 key1 pp0 read", status, 2);
    chk("R6 key1 pp0 perms", {pr, pw}, 0);
    chk("R8 ref on prot", w1_at(0, 2), 32'hABCD_E100);

    setup(32'h2000_0123, 32'h0020_0000);
    put(0, 2, w0_of(EA, 32'h123, 0), 32'hABCD_E003);
    run(0, 1, 1);
    chk("R6 key1 pp3 store", status, 2);
    chk("R6 key1 pp3 perms", {pr, pw}, 2'b10);
    run(0, 0, 1);
    chk("R6 key1 pp3 read", status, 0);
    chk("R8 no rewrite", wr_cnt, 0);

    setup(32'h4000_0123, 32'h0020_0000);
    put(0, 1, w0_of(EA, 32'h123, 0), 32'hABCD_E002);
    run(0, 1, 0);
    chk("R1 supervisor key1 pp2 store", status, 0);
    chk("R6 key1 pp2 perms", {pr, pw}, 2'b11);

    setup(32'h2000_0123, 32'h0020_0000);
    put(0, 1, w0_of(EA, 32'h123, 0), 32'hABCD_E003);
    run(0, 1, 0);
    chk("R1 supervisor ignores user key", status, 2);
  endtask

  task automatic t_noexec;
    setup(32'h1000_0123, 32'h0020_0000);
    put(0, 0, w0_of(EA, 32'h123, 0), 32'hABCD_E002);
    run(1, 0, 0);
    chk("R2 noexec status", status, 3);
    chk("R2 noexec no reads", rd_cnt, 0);
    chk("R9 noexec clean", {rpn, pr, pw}, 0);
    setup(32'h8000_0123, 32'h0020_0000);
    run(0, 0, 0);
    chk("R2 direct segment miss", status, 1);
    chk("R2 direct no reads", rd_cnt, 0);
  endtask

  task automatic t_conflict;
    setup(32'h0000_0123, 32'h0020_0000);
    put(0, 1, w0_of(EA, 32'h123, 0), 32'hABCD_E002);
    put(0, 5, w0_of(EA, 32'h123, 0), 32'hBBBB_B002);
    run(0, 0, 0);
    chk("R7 conflict miss", status, 1);
    chk("R7 conflict no write", wr_cnt, 0);
    chk("R7 entry untouched", w1_at(0, 1), 32'hABCD_E002);
    setup(32'h0000_0123, 32'h0020_0000);
    put(0, 1, w0_of(EA, 32'h123, 0), 32'hABCD_E002);
    put(0, 5, w0_of(EA, 32'h123, 0), 32'hABCD_E182);
    run(0, 0, 0);
    chk("R7 agreeing duplicates", status, 0);
    chk("R7 first entry used", w1_at(0, 1), 32'hABCD_E102);
  endtask

  task automatic t_no_change;
    setup(32'h0000_0123, 32'h0020_0000);
    put(0, 4, w0_of(EA, 32'h123, 0), 32'hABCD_E182);
    run(0, 1, 0);
    chk("R8 flags set no write", wr_cnt, 0);
    chk("R8 store perms kept", {pr, pw}, 2'b11);
  endtask

  task automatic t_prot_combine;
    setup(32'h2000_0123, 32'h0020_0000);
    put(0, 0, w0_of(EA, 32'h123, 0), 32'h1111_1100);
    put(1, 7, w0_of(EA, 32'h123, 1), 32'h2222_2102);
    run(0, 0, 1);
    chk("R4 prot then secondary ok", status, 0);
    chk("R4 secondary rpn wins", rpn, 20'h22222);
    setup(32'h2000_0123, 32'h0020_0000);
    put(0, 0, w0_of(EA, 32'h123, 0), 32'h1111_1100);
    run(0, 0, 1);
    chk("R4 prot kept over miss", status, 2);
    chk("R9 prot rpn", rpn, 20'h11111);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_hit();
    t_write_hit();
    t_secondary();
    t_miss();
    t_keys();
    t_noexec();
    t_conflict();
    t_no_change();
    t_prot_combine();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule